// File: doc/BRIEF.md
# Clock Divider Change Sequencer

This controller moves a core clock from its present divide ratio to a requested one. The allowed ratios are 1, 2, 4, 6 and 8. While the ratio changes, the refresh settings of an attached DRAM controller stay valid. The block owns three control fields:
- the divider-select code;
- the self-refresh enable bit;
- the refresh-count field, in units of 64 divided clocks.

It orders its writes to these fields so that memory refresh is never starved. All waiting is done by counting cycles of the undivided base clock.

A requester presents a ratio index and a one-cycle start strobe. While a change is in progress the block holds busy high. It reports completion with a one-cycle done pulse, and raises an error flag alongside that pulse when the index was not legal. A change between ratio 1 and a ratio above 2 always passes through ratio 2. The clock generator, its PLL and the DRAM controller lie outside the block; only their control fields appear at its ports.

Top module: `clk_ratio_seq`

## Requirements
- R1: After reset the divider code is 000, self-refresh is off, the refresh count holds the value for ratio 1, and busy, done and err are low.
- R2: Index 0..4 selects ratios 1, 2, 4, 6, 8. When the change completes, the divider code is 000, 001, 011, 010, 100 respectively.
- R3: When a change completes, the refresh count equals BASE_HZ × 7800 / (64 × ratio × 10^9), rounded down and clamped to 127.
- R4: A 2→1 move clears self-refresh, then writes the divider code, then rewrites the refresh count.
- R5: A 1→2 move rewrites the refresh count, then writes the divider code, then sets self-refresh. Self-refresh is therefore on at every ratio of 2 or above.
- R6: Changes between ratio 1 and ratio 4, 6 or 8 pass through ratio 2, so code 001 is the first divider code written.
- R7: Between ratios of 2 or more, a growing divider gets its refresh count rewritten before the divider write. A shrinking divider gets the divider write first and the refresh count after it.
- R8: The next control-field change follows a divider write by exactly LOCK_CYCLES+1 base cycles.
- R9: The drain wait applies in a 1→2 move or a shrinking move, when self-refresh reads back off after the refresh rewrite. The divider write then follows the refresh write by 64 × (old_count + new_count) × old_ratio + DRAIN_MARGIN + 1 cycles.
- R10: A request for the ratio already in place pulses done in the next cycle. busy stays low and no field changes.
- R11: An index above 4 pulses done together with err in the next cycle, and no field changes.
- R12: A start strobe that arrives while busy is high is ignored, and the original target is reached.
- R13: busy is high from the cycle after start until done. done lasts one cycle, and busy is low while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Undivided base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| tgt_idx_i | input | 3 | Requested ratio index (0..4) |
| busy_o | output | 1 | Change in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal index, valid with done_o |
| div_sel_o | output | 3 | Divider-select code |
| sref_en_o | output | 1 | DRAM self-refresh enable |
| refr_cnt_o | output | 7 | DRAM refresh count |

## Verification
The bench logs every change of the three control fields with its cycle stamp and compares the order of writes in each transaction against the expected sequence. A design that wrote the divider too early, or skipped the pass through ratio 2, shows a different write order or a first divider code other than 001. The bench measures the gap after each divider write and the drain gap of each 1→2 move exactly. A shortened PLL lock wait, a wrong old/new count sum or a wrong ratio in the drain product therefore shows up as a wrong cycle count. Same-ratio and illegal requests are checked for a one-cycle done with no field activity, and a second strobe during a change is checked for having no effect on the final ratio.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_SR_CLR, S_REFR, S_DRAIN, S_DIV, S_LOCK, S_SR_SET, S_NEXT
  } st_e;

  typedef enum logic [1:0] {K_UP12, K_DN21, K_GROW, K_SHRINK} kind_e;

  function automatic logic [2:0] ratio_code(int unsigned idx);
    case (idx)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic int unsigned ratio_div(int unsigned idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int unsigned refr_count(longint unsigned hz, int unsigned ns,
                                             int unsigned per, int unsigned div,
                                             int unsigned maxv);
    longint unsigned num, den, q;
    num = hz * longint'(ns);
    den = longint'(per) * longint'(div) * 64'd1_000_000_000;
    q   = num / den;
    if (q > longint'(maxv)) return maxv;
    return int'(q);
  endfunction
endpackage

// File: rtl/crs_ratio_lut.sv
module crs_ratio_lut import crs_pkg::*; #(
  parameter longint unsigned BASE_HZ = 500_000_000,
  parameter int unsigned REFR_NS     = 7800,
  parameter int unsigned CLKS_PER_CNT = 64,
  parameter int unsigned NUM_RATIOS  = 5,
  parameter int unsigned CNT_W       = 7,
  localparam int unsigned IDX_W      = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [2:0]       code_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [2:0]       code_tab [NUM_RATIOS];
  logic [CNT_W-1:0] cnt_tab  [NUM_RATIOS];

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_ent
    localparam int unsigned CNT_G =
      refr_count(BASE_HZ, REFR_NS, CLKS_PER_CNT, ratio_div(g), CNT_MAX);
    assign code_tab[g] = ratio_code(g);
    assign cnt_tab[g]  = CNT_W'(CNT_G);
  end

  always_comb begin
    code_o = '0;
    cnt_o  = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (idx_i == IDX_W'(i)) begin
        code_o = code_tab[i];
        cnt_o  = cnt_tab[i];
      end
    end
  end
endmodule

// File: rtl/crs_wait_timer.sv
module crs_wait_timer #(
  parameter int unsigned TW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - TW'(1);
  end

  // expire marks the last cycle of a wait of val_i cycles
  assign expire_o = (cnt_q == TW'(1));

  // R8
  // no_reload_while_counting_chk: a wait is never cut short by a new load
  no_reload_while_counting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q <= TW'(1)));
endmodule

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq import crs_pkg::*; #(
  parameter longint unsigned BASE_HZ  = 500_000_000,
  parameter int unsigned REFR_NS      = 7800,
  parameter int unsigned CLKS_PER_CNT = 64,
  parameter int unsigned LOCK_CYCLES  = 16,
  parameter int unsigned DRAIN_MARGIN = 64,
  parameter int unsigned CNT_W        = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       tgt_idx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       div_sel_o,
  output logic             sref_en_o,
  output logic [CNT_W-1:0] refr_cnt_o
);
  localparam int unsigned NUM_RATIOS = 5;
  localparam int unsigned IDX_W      = 3;
  localparam int unsigned CNT_MAX    = (1 << CNT_W) - 1;
  localparam int unsigned DRAIN_MAX  = CLKS_PER_CNT * 2 * CNT_MAX * 8 + DRAIN_MARGIN;
  localparam int unsigned TW         = $clog2(DRAIN_MAX + 1);
  localparam logic [CNT_W-1:0] REFR_RST =
    CNT_W'(refr_count(BASE_HZ, REFR_NS, CLKS_PER_CNT, 1, CNT_MAX));

  st_e              st_q;
  kind_e            kind_q, nxt_kind;
  logic [IDX_W-1:0] cur_q, hop_q, fin_q, nxt_hop;
  logic [2:0]       div_q, hop_code;
  logic             sref_q, done_q, err_q;
  logic [CNT_W-1:0] refr_q, hop_cnt;
  logic             tmr_load, tmr_exp, drain_need;
  logic [TW-1:0]    tmr_val, drain_val;

  crs_ratio_lut #(
    .BASE_HZ(BASE_HZ), .REFR_NS(REFR_NS), .CLKS_PER_CNT(CLKS_PER_CNT),
    .NUM_RATIOS(NUM_RATIOS), .CNT_W(CNT_W)
  ) u_lut (
    .idx_i(hop_q), .code_o(hop_code), .cnt_o(hop_cnt)
  );

  crs_wait_timer #(.TW(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val),
    .expire_o(tmr_exp)
  );

  // route 1 <-> {4,6,8} through ratio 2
  always_comb begin
    if ((cur_q == '0 && fin_q >= IDX_W'(2)) || (cur_q >= IDX_W'(2) && fin_q == '0))
      nxt_hop = IDX_W'(1);
    else
      nxt_hop = fin_q;
    if (cur_q == '0 && nxt_hop == IDX_W'(1))      nxt_kind = K_UP12;
    else if (cur_q == IDX_W'(1) && nxt_hop == '0) nxt_kind = K_DN21;
    else if (nxt_hop > cur_q)                     nxt_kind = K_GROW;
    else                                          nxt_kind = K_SHRINK;
  end

  // refr_q still holds the old count when S_REFR evaluates this
  assign drain_need = (kind_q == K_UP12 || kind_q == K_SHRINK) && !sref_q;
  assign drain_val  = TW'(CLKS_PER_CNT) * (TW'(refr_q) + TW'(hop_cnt))
                    * TW'(ratio_div(32'(cur_q))) + TW'(DRAIN_MARGIN);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(LOCK_CYCLES);
    if (st_q == S_DIV) begin
      tmr_load = 1'b1;
    end else if (st_q == S_REFR && drain_need) begin
      tmr_load = 1'b1;
      tmr_val  = drain_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      kind_q <= K_UP12;
      cur_q  <= '0;
      hop_q  <= '0;
      fin_q  <= '0;
      div_q  <= 3'b000;
      sref_q <= 1'b0;
      refr_q <= REFR_RST;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (tgt_idx_i >= IDX_W'(NUM_RATIOS)) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (tgt_idx_i == cur_q) begin
            done_q <= 1'b1;
          end else begin
            fin_q <= tgt_idx_i;
            st_q  <= S_PLAN;
          end
        end
        S_PLAN: if (cur_q == fin_q) begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end else begin
          hop_q  <= nxt_hop;
          kind_q <= nxt_kind;
          case (nxt_kind)
            K_UP12, K_GROW: st_q <= S_REFR;
            K_DN21:         st_q <= S_SR_CLR;
            default:        st_q <= S_DIV;
          endcase
        end
        S_SR_CLR: begin
          sref_q <= 1'b0;
          st_q   <= S_DIV;
        end
        S_REFR: begin
          refr_q <= hop_cnt;
          if (drain_need)
            st_q <= S_DRAIN;
          else
            st_q <= (kind_q == K_UP12 || kind_q == K_GROW) ? S_DIV : S_NEXT;
        end
        S_DRAIN: if (tmr_exp) st_q <= (kind_q == K_UP12) ? S_DIV : S_NEXT;
        S_DIV: begin
          div_q <= hop_code;
          st_q  <= S_LOCK;
        end
        S_LOCK: if (tmr_exp) begin
          case (kind_q)
            K_UP12:  st_q <= S_SR_SET;
            K_GROW:  st_q <= S_NEXT;
            default: st_q <= S_REFR;
          endcase
        end
        S_SR_SET: begin
          sref_q <= 1'b1;
          st_q   <= S_NEXT;
        end
        S_NEXT: begin
          cur_q <= hop_q;
          st_q  <= S_PLAN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign div_sel_o  = div_q;
  assign sref_en_o  = sref_q;
  assign refr_cnt_o = refr_q;

  // R2
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_sel_o inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100});
  // R8
  lock_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOCK) |=> ($stable(div_sel_o) && $stable(sref_en_o) && $stable(refr_cnt_o)));
  // R12
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(fin_q));
  // R13
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R13
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R11
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  // R5
  sref_above_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && div_sel_o != 3'b000) |-> sref_en_o);
endmodule

// File: tb/clk_ratio_seq_tb.sv
`timescale 1ns/1ps
module clk_ratio_seq_tb;
  localparam longint unsigned BASE_HZ = 500_000_000;
  localparam int unsigned LOCK   = 16;
  localparam int unsigned MARGIN = 64;
  localparam int unsigned PERCNT = 64;
  localparam int unsigned NVEC   = 11;
  // {tgt[2:0], through_2, drain, write-order signature}
  // signature nibbles: 1 refresh write, 2 divider write, 3 sref set, 4 sref clear
  localparam logic [28:0] VEC [NVEC] = '{
    {3'd1, 1'b0, 1'b1, 24'h000123},
    {3'd3, 1'b0, 1'b0, 24'h000012},
    {3'd2, 1'b0, 1'b0, 24'h000021},
    {3'd0, 1'b0, 1'b0, 24'h021421},
    {3'd4, 1'b1, 1'b1, 24'h012312},
    {3'd4, 1'b0, 1'b0, 24'h000000},
    {3'd1, 1'b0, 1'b0, 24'h000021},
    {3'd0, 1'b0, 1'b0, 24'h000421},
    {3'd2, 1'b1, 1'b1, 24'h012312},
    {3'd7, 1'b0, 1'b0, 24'h000000},
    {3'd0, 1'b0, 1'b0, 24'h021421}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] tgt_idx_i = '0;
  logic busy_o, done_o, err_o, sref_en_o;
  logic [2:0] div_sel_o;
  logic [6:0] refr_cnt_o;

  always #4 clk = ~clk;

  clk_ratio_seq #(.BASE_HZ(BASE_HZ), .LOCK_CYCLES(LOCK), .DRAIN_MARGIN(MARGIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .tgt_idx_i(tgt_idx_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .div_sel_o(div_sel_o),
    .sref_en_o(sref_en_o), .refr_cnt_o(refr_cnt_o)
  );

  int n_chk = 0, n_fail = 0;

  function automatic logic [2:0] exp_code(int i);
    case (i) 0: return 3'b000; 1: return 3'b001; 2: return 3'b011;
      3: return 3'b010; default: return 3'b100; endcase
  endfunction
  function automatic int exp_ratio(int i);
    case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
  endfunction
  function automatic int exp_cnt(int i);
    longint unsigned q;
    q = (BASE_HZ * 64'd7800) / (64'd64 * longint'(exp_ratio(i)) * 64'd1_000_000_000);
    return (q > 127) ? 127 : int'(q);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // field-change log sampled at negedge
  int cyc = 0, ev_n = 0;
  int ev_ty [64];
  int ev_cyc [64];
  int ev_val [64];
  logic [2:0] p_div; logic p_sr; logic [6:0] p_refr;

  task automatic rec(input int ty, input int val);
    if (ev_n < 64) begin
      ev_ty[ev_n] = ty; ev_cyc[ev_n] = cyc; ev_val[ev_n] = val;
    end
    ev_n++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (refr_cnt_o != p_refr) rec(1, int'(refr_cnt_o));
      if (div_sel_o != p_div)   rec(2, int'(div_sel_o));
      if (sref_en_o != p_sr)    rec(sref_en_o ? 3 : 4, int'(sref_en_o));
    end
    p_div = div_sel_o; p_sr = sref_en_o; p_refr = refr_cnt_o;
  end

  task automatic run_txn(input logic [2:0] tgt, output int lat, output int b0,
                         output int b1, output logic e, output logic got, output logic bbad);
    b0 = ev_n; lat = 0; got = 0; bbad = 0; e = 0;
    @(negedge clk); start_i = 1'b1; tgt_idx_i = tgt;
    while (!got && lat < 20000) begin
      @(negedge clk); start_i = 1'b0; lat++;
      if (done_o) begin
        got = 1; e = err_o;
        if (busy_o) bbad = 1;
      end else if (!busy_o) bbad = 1;
    end
    b1 = ev_n;
  endtask

  task automatic chk_reset_state(input string tag);
    chk(div_sel_o == 3'b000, {tag, " R1 div"}, div_sel_o, 0);
    chk(sref_en_o == 1'b0,   {tag, " R1 sref"}, sref_en_o, 0);
    chk(refr_cnt_o == 7'(exp_cnt(0)), {tag, " R1 refr"}, refr_cnt_o, exp_cnt(0));
    chk(!busy_o && !done_o && !err_o, {tag, " R1 flags"}, {busy_o, done_o, err_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cur = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_reset_state("first");

    for (int v = 0; v < NVEC; v++) begin
      int lat, b0, b1, tgt, sig, exp_sig, fdiv;
      logic e, got, bbad;
      tgt = int'(VEC[v][28:26]);
      exp_sig = int'(VEC[v][23:0]);
      run_txn(VEC[v][28:26], lat, b0, b1, e, got, bbad);
      chk(got && !bbad, "R13 busy/done", {got, bbad}, 2);
      if (tgt > 4) begin
        chk(e == 1'b1, "R11 err", e, 1);
        chk(lat == 1, "R11 latency", lat, 1);
      end else begin
        chk(e == 1'b0, "R11 no err", e, 0);
        if (tgt == cur) chk(lat == 1, "R10 latency", lat, 1);
        cur = tgt;
      end
      sig = 0;
      for (int k = b0; k < b1; k++) sig = (sig << 4) | ev_ty[k];
      chk(sig == exp_sig, "R4 R5 R6 R7 R10 write order", sig, exp_sig);
      chk(div_sel_o == exp_code(cur), "R2 code", div_sel_o, exp_code(cur));
      chk(refr_cnt_o == 7'(exp_cnt(cur)), "R3 refr", refr_cnt_o, exp_cnt(cur));
      chk(sref_en_o == (cur != 0), "R5 sref", sref_en_o, cur != 0);
      for (int k = b0; k + 1 < b1; k++)
        if (ev_ty[k] == 2)
          chk(ev_cyc[k+1] - ev_cyc[k] == LOCK + 1, "R8 lock gap",
              ev_cyc[k+1] - ev_cyc[k], LOCK + 1);
      if (VEC[v][25]) begin
        fdiv = -1;
        for (int k = b1 - 1; k >= b0; k--) if (ev_ty[k] == 2) fdiv = ev_val[k];
        chk(fdiv == 1, "R6 via ratio 2", fdiv, 1);
      end
      if (VEC[v][24]) begin
        int want = int'(PERCNT) * (exp_cnt(0) + exp_cnt(1)) * 1 + int'(MARGIN) + 1;
        chk(ev_cyc[b0+1] - ev_cyc[b0] == want, "R9 drain gap",
            ev_cyc[b0+1] - ev_cyc[b0], want);
      end
    end

    // R12: second strobe during a change is ignored
    begin
      int seen_done = 0, lat = 0;
      @(negedge clk); start_i = 1'b1; tgt_idx_i = 3'd1;
      @(negedge clk); start_i = 1'b0;
      repeat (8) @(negedge clk);
      start_i = 1'b1; tgt_idx_i = 3'd4;
      @(negedge clk); start_i = 1'b0;
      while (seen_done == 0 && lat < 20000) begin
        @(negedge clk); lat++;
        if (done_o) seen_done = 1;
      end
      repeat (30) @(negedge clk);
      chk(div_sel_o == 3'b001, "R12 target kept", div_sel_o, 1);
      chk(!busy_o, "R12 idle after", busy_o, 0);
    end

    // R1: asynchronous reset restores the reset state
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk_reset_state("mid reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_reset_state("second");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule